// File: doc/BRIEF.md
# Mailbox Interrupt Request Generator

This block turns completion events from a 32-mailbox message controller into two interrupt requests, one for transmit and one for receive. A 32-bit enable register, written and read by the CPU, decides which events may raise a request. Each mailbox reports a transmit-done or receive-done pulse on its own bit. A transmit queue reports completions together with a flag that is high when that completion left the queue empty. A receive queue reports completions together with its current count of unread messages.

The register means different things in the two modes. In normal mode (`fifo_mode` = 0) bit i gates mailbox i for all 32 mailboxes, and the queue inputs have no effect. In queue mode (`fifo_mode` = 1) only bits 23..0 gate mailboxes 23..0, and events on mailboxes 24..31 are ignored. The upper bits then control the queues:
- bit 24 enables the transmit queue request;
- bit 25 selects when it fires: 0 on every completion, 1 only on a completion that empties the queue;
- bit 28 enables the receive queue request;
- bit 29 selects when it fires: 0 on every reception, 1 only on a reception that lifts the unread count from below the watermark (3) to exactly the watermark.

Bits 26, 27, 30 and 31 are reserved in queue mode.

A four-state level tracker follows the receive queue's unread count. Its states are `LVL_SYNC`, `LVL_BELOW`, `LVL_AT` and `LVL_ABOVE`.
- `LVL_SYNC` is the state after reset, when the previous count is not known.
- Every cycle the tracker moves to `LVL_BELOW`, `LVL_AT` or `LVL_ABOVE` according to the current count. This holds from every state: SYNC to zone, BELOW to zone, AT to zone and ABOVE to zone.
- The watermark event exists only while the state is `LVL_BELOW` and the count equals the watermark.

Each request is a registered single-cycle pulse. It rises in the cycle after the qualifying event is sampled.

Top module: `mbox_irq_gen`

## Requirements
- R1: After reset the enable register reads 0 and `tx_irq` and `rx_irq` are low.
- R2: In normal mode a value written with `cfg_wr_en` is stored on the clock edge and reads back unchanged on `cfg_rd_data` from the next cycle.
- R3: In normal mode, a `mb_tx_done[i]` pulse with enable bit i set gives `tx_irq` high one cycle later. With bit i clear it gives no request.
- R4: In normal mode, a `mb_rx_done[i]` pulse with enable bit i set gives `rx_irq` high one cycle later. With bit i clear it gives no request.
- R5: In queue mode, bits 23..0 gate mailboxes 23..0 as in R3/R4. Pulses on mailboxes 24..31 raise no request whatever the register holds.
- R6: In queue mode with bit 24 = 1 and bit 25 = 0, every `txq_done` pulse gives a `tx_irq` pulse. With bit 24 = 0 it gives none.
- R7: In queue mode with bits 24 and 25 both set, `txq_done` gives a request only when `txq_empty` is high in the same cycle.
- R8: In queue mode with bit 28 = 1 and bit 29 = 0, every `rxq_done` pulse gives an `rx_irq` pulse. With bit 28 = 0 it gives none.
- R9: In queue mode with bits 28 and 29 both set, a request is raised only when `rxq_done` is high, `rxq_count` equals 3, and the count in the previous cycle was below 3.
- R10: A receive count that reaches 3 from above (4 or more) raises no threshold request. The first cycle after reset raises none either.
- R11: In queue mode, bits 26, 27, 30 and 31 are stored as 0 whatever is written and read back as 0.
- R12: Transmit and receive requests are independent; both pulse in the same cycle when both have a qualifying event.
- R13: A request lasts one cycle per qualifying cycle: the output is low in any cycle that follows a cycle with no qualifying event.
- R14: In normal mode the queue inputs (`txq_done`, `txq_empty`, `rxq_done`, `rxq_count`) raise no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 0 = normal mode, 1 = queue mode |
| cfg_wr_en | input | 1 | Write strobe for the enable register |
| cfg_wr_data | input | 32 | Write data for the enable register |
| cfg_rd_data | output | 32 | Enable register read value |
| mb_tx_done | input | 32 | Per-mailbox transmit completion pulses |
| mb_rx_done | input | 32 | Per-mailbox receive completion pulses |
| txq_done | input | 1 | Transmit queue completion pulse |
| txq_empty | input | 1 | Transmit queue empty after this completion |
| rxq_done | input | 1 | Receive queue reception completion pulse |
| rxq_count | input | CNT_W | Unread messages in the receive queue |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The hardest case to reach from the ports is the receive threshold decision. It depends on the count the tracker saw one cycle before the reception, and that history cannot be read from outside. For every threshold vector the bench therefore holds `rxq_count` at a chosen previous value for a full cycle while it writes the enable register. Only then does it apply the reception with the new count. This lets it place the below-to-watermark crossing, the fall from full, a rise past the watermark and a crossing with no reception side by side. Reserved-bit storage is proven by writing all ones in queue mode and reading back after the mode is changed.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    localparam int MB_NUM      = 32;
    localparam int FIFO_MB_NUM = 24;

    localparam int TXQ_EN_BIT  = 24;
    localparam int TXQ_SEL_BIT = 25;
    localparam int RXQ_EN_BIT  = 28;
    localparam int RXQ_SEL_BIT = 29;

    localparam logic [MB_NUM-1:0] RSV_MASK = 32'hCC00_0000;

    typedef enum logic [1:0] {
        LVL_SYNC  = 2'd0,
        LVL_BELOW = 2'd1,
        LVL_AT    = 2'd2,
        LVL_ABOVE = 2'd3
    } rxq_lvl_e;

    typedef struct packed {
        logic txq_en;
        logic txq_sel;
        logic rxq_en;
        logic rxq_sel;
    } queue_ctl_t;

endpackage

// File: rtl/mbox_irq_enreg.sv
module mbox_irq_enreg
    import mbox_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              wr_en,
    input  logic [MB_NUM-1:0] wr_data,
    output logic [MB_NUM-1:0] en_q,
    output logic [MB_NUM-1:0] rd_data
);

    logic [MB_NUM-1:0] keep_mask;

    // reserved positions only exist in queue mode
    always_comb begin
        keep_mask = fifo_mode ? ~RSV_MASK : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_data & keep_mask;
        end
    end

    always_comb begin
        rd_data = en_q & keep_mask;
    end

endmodule

// File: rtl/mbox_irq_rxlvl.sv
module mbox_irq_rxlvl
    import mbox_irq_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int WARN_LEVEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rxq_count,
    output logic             warn_hit
);

    localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(WARN_LEVEL);

    rxq_lvl_e state_q;
    rxq_lvl_e state_d;
    rxq_lvl_e zone;
    logic     at_level;

    // zone the current count falls into
    always_comb begin
        at_level = (rxq_count == WARN_CNT);
        if (rxq_count < WARN_CNT) begin
            zone = LVL_BELOW;
        end else if (at_level) begin
            zone = LVL_AT;
        end else begin
            zone = LVL_ABOVE;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_SYNC:  state_d = zone;
            LVL_BELOW: state_d = zone;
            LVL_AT:    state_d = zone;
            LVL_ABOVE: state_d = zone;
            default:   state_d = LVL_SYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    // crossing exists only when coming up from below
    always_comb begin
        warn_hit = 1'b0;
        unique case (state_q)
            LVL_BELOW: warn_hit = at_level;
            LVL_SYNC,
            LVL_AT,
            LVL_ABOVE: warn_hit = 1'b0;
            default:   warn_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbox_irq_route.sv
module mbox_irq_route
    import mbox_irq_pkg::*;
(
    input  logic              fifo_mode,
    input  logic [MB_NUM-1:0] en,
    input  logic [MB_NUM-1:0] mb_done,
    input  logic              queue_evt,
    output logic              req_d
);

    logic [MB_NUM-1:0] hit;

    for (genvar i = 0; i < MB_NUM; i++) begin : g_gate
        if (i < FIFO_MB_NUM) begin : g_shared
            assign hit[i] = mb_done[i] & en[i];
        end else begin : g_normal_only
            assign hit[i] = mb_done[i] & en[i] & ~fifo_mode;
        end
    end

    always_comb begin
        req_d = (|hit) | (fifo_mode & queue_evt);
    end

endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen
    import mbox_irq_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int WARN_LEVEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic             cfg_wr_en,
    input  logic [31:0]      cfg_wr_data,
    output logic [31:0]      cfg_rd_data,
    input  logic [31:0]      mb_tx_done,
    input  logic [31:0]      mb_rx_done,
    input  logic             txq_done,
    input  logic             txq_empty,
    input  logic             rxq_done,
    input  logic [CNT_W-1:0] rxq_count,
    output logic             tx_irq,
    output logic             rx_irq
);

    logic [MB_NUM-1:0] en_q;
    queue_ctl_t        ctl;
    logic              warn_hit;
    logic              txq_evt;
    logic              rxq_evt;
    logic              tx_req_d;
    logic              rx_req_d;

    mbox_irq_enreg u_enreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .en_q      (en_q),
        .rd_data   (cfg_rd_data)
    );

    mbox_irq_rxlvl #(
        .CNT_W      (CNT_W),
        .WARN_LEVEL (WARN_LEVEL)
    ) u_rxlvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxq_count (rxq_count),
        .warn_hit  (warn_hit)
    );

    always_comb begin
        ctl.txq_en  = en_q[TXQ_EN_BIT];
        ctl.txq_sel = en_q[TXQ_SEL_BIT];
        ctl.rxq_en  = en_q[RXQ_EN_BIT];
        ctl.rxq_sel = en_q[RXQ_SEL_BIT];
        txq_evt = ctl.txq_en & txq_done & (~ctl.txq_sel | txq_empty);
        rxq_evt = ctl.rxq_en & rxq_done & (~ctl.rxq_sel | warn_hit);
    end

    mbox_irq_route u_tx_route (
        .fifo_mode (fifo_mode),
        .en        (en_q),
        .mb_done   (mb_tx_done),
        .queue_evt (txq_evt),
        .req_d     (tx_req_d)
    );

    mbox_irq_route u_rx_route (
        .fifo_mode (fifo_mode),
        .en        (en_q),
        .mb_done   (mb_rx_done),
        .queue_evt (rxq_evt),
        .req_d     (rx_req_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;
        end else begin
            tx_irq <= tx_req_d;
            rx_irq <= rx_req_d;
        end
    end

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int CNT_W      = 3,
    parameter int WARN_LEVEL = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_mode,
    input logic [31:0]      cfg_rd_data,
    input logic [31:0]      mb_tx_done,
    input logic [31:0]      mb_rx_done,
    input logic             txq_done,
    input logic             txq_empty,
    input logic             rxq_done,
    input logic [CNT_W-1:0] rxq_count,
    input logic             tx_irq,
    input logic             rx_irq
);

    localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(WARN_LEVEL);

    p_tx_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && (|(mb_tx_done & cfg_rd_data))) |=> tx_irq);

    p_rx_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && (|(mb_rx_done & cfg_rd_data))) |=> rx_irq);

    p_upper_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && mb_tx_done[23:0] == 24'd0 && !txq_done) |=> !tx_irq);

    p_txq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && cfg_rd_data[24] && cfg_rd_data[25] && txq_done && !txq_empty
         && (mb_tx_done[23:0] & cfg_rd_data[23:0]) == 24'd0) |=> !tx_irq);

    p_warn_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && cfg_rd_data[28] && cfg_rd_data[29] && rxq_done
         && rxq_count == WARN_CNT && $past(rxq_count) < WARN_CNT && $past(rst_n))
        |=> rx_irq);

    p_no_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && cfg_rd_data[28] && cfg_rd_data[29]
         && $past(rxq_count) > WARN_CNT
         && (mb_rx_done[23:0] & cfg_rd_data[23:0]) == 24'd0) |=> !rx_irq);

    p_rsv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode |-> (cfg_rd_data & 32'hCC00_0000) == 32'd0);

    p_tx_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past((|mb_tx_done) || txq_done));

    p_rx_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past((|mb_rx_done) || rxq_done));

endmodule

bind mbox_irq_gen mbox_irq_chk #(
    .CNT_W      (CNT_W),
    .WARN_LEVEL (WARN_LEVEL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode   (fifo_mode),
    .cfg_rd_data (cfg_rd_data),
    .mb_tx_done  (mb_tx_done),
    .mb_rx_done  (mb_rx_done),
    .txq_done    (txq_done),
    .txq_empty   (txq_empty),
    .rxq_done    (rxq_done),
    .rxq_count   (rxq_count),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq)
);

// File: tb/test_mbox_irq_gen.sv
module test_mbox_irq_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 3;
    localparam int NVEC       = 16;

    typedef struct packed {
        logic             mode;
        logic [31:0]      en;
        logic [31:0]      txmb;
        logic [31:0]      rxmb;
        logic             tqd;
        logic             tqe;
        logic             rqd;
        logic [CNT_W-1:0] prev;
        logic [CNT_W-1:0] cnt;
        logic             etx;
        logic             erx;
        logic [3:0]       req;
    } vec_t;

    // mode, enable, tx mbox, rx mbox, txq_done, txq_empty, rxq_done, prev cnt, cnt, exp tx, exp rx, req
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 4'd3},  // R3 enabled
        '{1'b0, 32'h0000_0001, 32'h0000_0002, 32'h0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd3},  // R3 disabled bit
        '{1'b0, 32'h8000_0000, 32'h0, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 4'd4},  // R4 top mailbox
        '{1'b0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, 3'd0, 3'd3, 1'b0, 1'b0, 4'd14}, // R14 queue inputs
        '{1'b1, 32'hFFFF_FFFF, 32'h0100_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd5}, // R5 upper ignored
        '{1'b1, 32'h0080_0000, 32'h0, 32'h0080_0000, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 4'd5},  // R5 mailbox 23
        '{1'b1, 32'h0100_0000, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 4'd6},  // R6 every completion
        '{1'b1, 32'h0000_0000, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 disabled
        '{1'b1, 32'h0300_0000, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 4'd7},  // R7 not empty
        '{1'b1, 32'h0300_0000, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 4'd7},  // R7 empty
        '{1'b1, 32'h1000_0000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1, 4'd8},  // R8 every reception
        '{1'b1, 32'h2000_0000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 3'd2, 3'd3, 1'b0, 1'b0, 4'd8},  // R8 disabled
        '{1'b1, 32'h3000_0000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 3'd2, 3'd3, 1'b0, 1'b1, 4'd9},  // R9 crossing
        '{1'b1, 32'h3000_0000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 3'd3, 3'd4, 1'b0, 1'b0, 4'd9},  // R9 past level
        '{1'b1, 32'h3000_0000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 3'd4, 3'd3, 1'b0, 1'b0, 4'd10}, // R10 from full
        '{1'b1, 32'h1100_0001, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 1'b1, 1'b1, 4'd12} // R12 both
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_mode = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [31:0]      cfg_wr_data = '0;
    logic [31:0]      cfg_rd_data;
    logic [31:0]      mb_tx_done = '0;
    logic [31:0]      mb_rx_done = '0;
    logic             txq_done = 1'b0;
    logic             txq_empty = 1'b0;
    logic             rxq_done = 1'b0;
    logic [CNT_W-1:0] rxq_count = '0;
    logic             tx_irq;
    logic             rx_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_gen #(.CNT_W(CNT_W), .WARN_LEVEL(3)) i_mbox_irq_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode   (fifo_mode),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .mb_tx_done  (mb_tx_done),
        .mb_rx_done  (mb_rx_done),
        .txq_done    (txq_done),
        .txq_empty   (txq_empty),
        .rxq_done    (rxq_done),
        .rxq_count   (rxq_count),
        .tx_irq      (tx_irq),
        .rx_irq      (rx_irq)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic clear_events();
        mb_tx_done = '0;
        mb_rx_done = '0;
        txq_done   = 1'b0;
        txq_empty  = 1'b0;
        rxq_done   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, "rd during reset", cfg_rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "rd after reset", cfg_rd_data, 32'h0);
        check(1, "tx after reset", {31'd0, tx_irq}, 32'h0);
        check(1, "rx after reset", {31'd0, rx_irq}, 32'h0);

        // R2 plain write and read in normal mode
        cfg_wr_en = 1'b1;
        cfg_wr_data = 32'hA5A5_5A5A;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(2, "readback", cfg_rd_data, 32'hA5A5_5A5A);

        // R11 reserved bits in queue mode
        fifo_mode = 1'b1;
        cfg_wr_en = 1'b1;
        cfg_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(11, "queue readback", cfg_rd_data, 32'h33FF_FFFF);
        fifo_mode = 1'b0;
        @(negedge clk);
        check(11, "stored zeros", cfg_rd_data, 32'h33FF_FFFF);

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            fifo_mode = VEC[k].mode;
            cfg_wr_en = 1'b1;
            cfg_wr_data = VEC[k].en;
            rxq_count = VEC[k].prev;
            clear_events();
            @(negedge clk);
            cfg_wr_en = 1'b0;
            mb_tx_done = VEC[k].txmb;
            mb_rx_done = VEC[k].rxmb;
            txq_done = VEC[k].tqd;
            txq_empty = VEC[k].tqe;
            rxq_done = VEC[k].rqd;
            rxq_count = VEC[k].cnt;
            @(negedge clk);
            check(int'(VEC[k].req), $sformatf("vec %0d tx", k), {31'd0, tx_irq}, {31'd0, VEC[k].etx});
            check(int'(VEC[k].req), $sformatf("vec %0d rx", k), {31'd0, rx_irq}, {31'd0, VEC[k].erx});
            clear_events();
            @(negedge clk);
            // R13 pulse ends once events stop
            check(13, $sformatf("vec %0d tx low", k), {31'd0, tx_irq}, 32'h0);
            check(13, $sformatf("vec %0d rx low", k), {31'd0, rx_irq}, 32'h0);
        end

        // R9 threshold with no reception does not fire
        fifo_mode = 1'b1;
        cfg_wr_en = 1'b1;
        cfg_wr_data = 32'h3000_0000;
        rxq_count = 3'd2;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        rxq_count = 3'd3;
        @(negedge clk);
        check(9, "count rise no reception", {31'd0, rx_irq}, 32'h0);

        // R10 fall from full then a reception held at 3 stays quiet
        rxq_count = 3'd4;
        @(negedge clk);
        rxq_count = 3'd3;
        @(negedge clk);
        rxq_done = 1'b1;
        @(negedge clk);
        rxq_done = 1'b0;
        check(10, "reception at level", {31'd0, rx_irq}, 32'h0);

        // R13 back-to-back events give back-to-back pulses
        fifo_mode = 1'b0;
        cfg_wr_en = 1'b1;
        cfg_wr_data = 32'h0000_0010;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        mb_tx_done = 32'h0000_0010;
        @(negedge clk);
        check(13, "first pulse", {31'd0, tx_irq}, 32'h1);
        @(negedge clk);
        check(13, "second pulse", {31'd0, tx_irq}, 32'h1);
        mb_tx_done = '0;
        @(negedge clk);
        check(13, "after burst", {31'd0, tx_irq}, 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule